// File: doc/BRIEF.md
# Prescaled Countdown Timer

A peripheral that software drives through a small word-addressed register port. Software loads a prescale value and a count value, then starts the timer. The prescaler splits the system clock into steps of a fixed number of cycles. The count drops by one at the end of each step, so the count measures elapsed time rather than raw clock cycles. The timer stops by itself when the count reaches zero. Software can also halt it early and later resume from the count that was held.

The port is one-cycle: a write takes effect at the clock edge on which chip-select and write-enable are high. Read data is combinational from the address while chip-select is high. The control word carries two self-clearing bits: bit 0 starts the timer and bit 1 halts it. The two reload registers cannot be written while the timer is running.

Top module: `ptmr_top`

## Requirements
- R1: After a synchronous active-high reset, the status word (address 0x09) reads 0, the prescale word (0x0a) reads 1 and the count word (0x0b) reads 1.
- R2: While the timer is idle, writing address 0x0a sets the prescale value and writing 0x0b sets the count value. Each value reads back unchanged from its own address.
- R3: While the timer is running, writes to 0x0a and 0x0b are ignored, and both values are left as they were.
- R4: Writing 1 to bit 0 of the control word (0x08) while idle sets status bit 0 from the next cycle on. The start is ignored when the count value is zero.
- R5: With prescale value P, a run consists of steps of exactly P cycles. The count first drops by one P cycles after the start edge, then once every P cycles, with no cycle left out between steps.
- R6: On the edge where the count reaches zero, status bit 0 clears by itself and the count stays at zero.
- R7: Writing 1 to bit 1 of the control word clears status bit 0 on the next edge, and the count holds its value. When bits 0 and 1 are written together, the halt takes priority.
- R8: Reading the control word, or any address other than 0x09, 0x0a and 0x0b, returns zero.
- R9: A start after a halt continues from the held count, and a full P-cycle step comes before the next decrement.
- R10: A start written while the timer is already running has no effect on the step timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select for the register port |
| we | input | 1 | Write enable, qualified by cs |
| addr | input | 8 | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when cs is low |

## Verification
The bench builds the block with its default 32-bit data width. It loads small prescale values (2, 3 and 4) and small counts, so each run reaches its end within a few dozen cycles. The timer value and the running flag are read on every cycle of a run, which pins down each step boundary, the automatic stop at zero, the hold after a halt, and the full step that comes after a resume. With 32-bit registers, writes of large values while running also show that the locked reload values are kept intact.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL  = 8'h08;
    localparam logic [ADDR_W-1:0] A_STAT  = 8'h09;
    localparam logic [ADDR_W-1:0] A_PRESC = 8'h0a;
    localparam logic [ADDR_W-1:0] A_COUNT = 8'h0b;

    localparam int unsigned CTRL_GO_BIT   = 0;
    localparam int unsigned CTRL_HALT_BIT = 1;
    localparam int unsigned STAT_RUN_BIT  = 0;

    typedef struct packed {
        logic go;
        logic halt;
    } ctrl_req_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_PRESC,
        SEL_COUNT
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            A_CTRL:  return SEL_CTRL;
            A_STAT:  return SEL_STAT;
            A_PRESC: return SEL_PRESC;
            A_COUNT: return SEL_COUNT;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
    import ptmr_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DW-1:0]       wdata,
    input  logic                running,
    input  logic [DW-1:0]       count_val,
    output ctrl_req_t           req,
    output logic                wr_count,
    output logic [DW-1:0]       presc_q,
    output logic [DW-1:0]       rdata
);

    reg_sel_e sel;
    logic     wr_any;

    assign sel    = decode_addr(addr);
    assign wr_any = cs && we;

    always_comb begin
        req.go   = wr_any && (sel == SEL_CTRL) && wdata[CTRL_GO_BIT];
        req.halt = wr_any && (sel == SEL_CTRL) && wdata[CTRL_HALT_BIT];
    end

    assign wr_count = wr_any && (sel == SEL_COUNT) && !running;

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= DW'(1);
        end else if (wr_any && (sel == SEL_PRESC) && !running) begin
            presc_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (cs) begin
            case (sel)
                SEL_STAT:  rdata[STAT_RUN_BIT] = running;
                SEL_PRESC: rdata = presc_q;
                SEL_COUNT: rdata = count_val;
                default:   rdata = '0;
            endcase
        end
    end

    // R3: the prescale value is frozen during a run
    p_presc_locked_r3: assert property (@(posedge clk) disable iff (rst)
        (running && cs && we && (addr == A_PRESC)) |=> (presc_q == $past(presc_q)));

    // R8: control word never reads back a value
    p_ctrl_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (cs && (addr == A_CTRL)) |-> (rdata == '0));

endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
    import ptmr_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          restart,
    input  logic [DW-1:0] presc,
    output logic          tick
);

    logic [DW-1:0] pc_q;
    logic [DW:0]   pc_next_wide;
    logic [DW:0]   bound;

    assign bound        = (presc == '0) ? (DW+1)'(1) : {1'b0, presc};
    assign pc_next_wide = {1'b0, pc_q} + (DW+1)'(1);
    assign tick         = run && !restart && (pc_next_wide >= bound);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (restart) begin
            pc_q <= '0;
        end else if (run) begin
            pc_q <= tick ? '0 : pc_next_wide[DW-1:0];
        end
    end

    // R5: the phase counter never passes the end of a step
    p_phase_bound_r5: assert property (@(posedge clk) disable iff (rst)
        run |-> ({1'b0, pc_q} < bound));

    // R9: a restart starts a full step from phase zero
    p_restart_phase_r9: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pc_q == '0));

endmodule

// File: rtl/ptmr_countdown.sv
module ptmr_countdown
    import ptmr_pkg::*;
#(
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_req_t     req,
    input  logic          wr_count,
    input  logic [DW-1:0] wdata,
    input  logic          tick,
    output logic          running,
    output logic          start_ok,
    output logic [DW-1:0] count_q
);

    assign start_ok = req.go && !req.halt && !running && (count_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            count_q <= DW'(1);
        end else if (req.halt) begin
            running <= 1'b0;
        end else if (start_ok) begin
            running <= 1'b1;
        end else if (running && tick) begin
            count_q <= count_q - DW'(1);
            if (count_q == DW'(1)) begin
                running <= 1'b0;
            end
        end else if (wr_count) begin
            count_q <= wdata;
        end
    end

    // R7: idle count only moves through a software write
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!running && !wr_count) |=> (count_q == $past(count_q)));

    // R5: one step removes exactly one unit
    p_step_one_r5: assert property (@(posedge clk) disable iff (rst)
        (running && tick && !req.halt) |=> (count_q == $past(count_q) - DW'(1)));

    // R6: a running timer never shows a zero count
    p_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        running |-> (count_q != '0));

    // R7: a halt stops the run on the next edge
    p_halt_r7: assert property (@(posedge clk) disable iff (rst)
        req.halt |=> !running);

    // R4: a start with zero count is refused
    p_zero_start_r4: assert property (@(posedge clk) disable iff (rst)
        (req.go && !running && (count_q == '0)) |=> !running);

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int unsigned DATA_W = ptmr_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    ctrl_req_t         req;
    logic              wr_count;
    logic [DATA_W-1:0] presc_q;
    logic [DATA_W-1:0] count_q;
    logic              running;
    logic              start_ok;
    logic              tick;

    ptmr_regs #(.DW(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cs        (cs),
        .we        (we),
        .addr      (addr),
        .wdata     (wdata),
        .running   (running),
        .count_val (count_q),
        .req       (req),
        .wr_count  (wr_count),
        .presc_q   (presc_q),
        .rdata     (rdata)
    );

    ptmr_prescale #(.DW(DATA_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .restart (start_ok),
        .presc   (presc_q),
        .tick    (tick)
    );

    ptmr_countdown #(.DW(DATA_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .wr_count (wr_count),
        .wdata    (wdata),
        .tick     (tick),
        .running  (running),
        .start_ok (start_ok),
        .count_q  (count_q)
    );

endmodule

// File: tb/ptmr_top_test.sv
module ptmr_top_test;
    import ptmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_run = 0;
    int n_fail = 0;
    bit chk_now = 1'b0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    ptmr_top uut (
        .clk(clk), .rst(rst), .cs(cs), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic op(input logic c, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input bit chk,
                      input logic [31:0] e, input string tag);
        @(negedge clk);
        cs = c; we = w; addr = a; wdata = d;
        chk_now = chk;
        if (chk) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        op(1'b1, 1'b1, a, d, 1'b0, '0, "");
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        op(1'b1, 1'b0, a, '0, 1'b1, e, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(1'b0, 1'b0, '0, '0, 1'b0, '0, "");
    endtask

    // monitor: pops expected items and compares mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (chk_now && exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_run++;
                if (rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", t, rdata, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(A_STAT, 32'd0, "R1 status");
        rd(A_PRESC, 32'd1, "R1 prescale");
        rd(A_COUNT, 32'd1, "R1 count");

        // R2 idle load and readback
        wr(A_PRESC, 32'd3);
        wr(A_COUNT, 32'd4);
        rd(A_PRESC, 32'd3, "R2 prescale");
        rd(A_COUNT, 32'd4, "R2 count");

        // R4 R5 R6 R3: P=3 T=4 run, observed every cycle
        wr(A_CTRL, 32'd1);
        for (int m = 1; m <= 14; m++) begin
            int v;
            v = 4 - (m - 1) / 3;
            if (v < 0) v = 0;
            if (m == 5) wr(A_PRESC, 32'd9);
            else if (m == 7) wr(A_COUNT, 32'd99);
            else if (m % 2 == 1) rd(A_COUNT, 32'(v), "R5 count step");
            else rd(A_STAT, (v > 0) ? 32'd1 : 32'd0, "R6 status");
        end
        rd(A_PRESC, 32'd3, "R3 prescale locked");
        rd(A_COUNT, 32'd0, "R6 count at zero");

        // R4 start refused with zero count
        wr(A_CTRL, 32'd1);
        rd(A_STAT, 32'd0, "R4 zero start");
        rd(A_COUNT, 32'd0, "R4 zero start count");

        // R7 halt and hold, P=2 T=10
        wr(A_PRESC, 32'd2);
        wr(A_COUNT, 32'd10);
        wr(A_CTRL, 32'd1);
        idle(4);
        wr(A_CTRL, 32'd2);
        rd(A_STAT, 32'd0, "R7 halted");
        rd(A_COUNT, 32'd8, "R7 held count");
        idle(3);
        rd(A_COUNT, 32'd8, "R7 still held");

        // R9 resume with a full step
        wr(A_CTRL, 32'd1);
        rd(A_COUNT, 32'd8, "R9 resume m1");
        rd(A_COUNT, 32'd8, "R9 resume m2");
        rd(A_COUNT, 32'd7, "R9 resume m3");
        rd(A_STAT, 32'd1, "R9 running");
        wr(A_CTRL, 32'd2);
        rd(A_COUNT, 32'd6, "R7 held after resume");

        // R7 start and halt together: halt wins
        wr(A_CTRL, 32'd3);
        rd(A_STAT, 32'd0, "R7 both bits");
        rd(A_COUNT, 32'd6, "R7 both bits count");

        // R10 second start mid-run, P=4 T=3
        wr(A_PRESC, 32'd4);
        wr(A_COUNT, 32'd3);
        wr(A_CTRL, 32'd1);
        idle(1);
        wr(A_CTRL, 32'd1);
        rd(A_COUNT, 32'd3, "R10 m3");
        rd(A_COUNT, 32'd3, "R10 m4");
        rd(A_COUNT, 32'd2, "R10 m5");
        wr(A_CTRL, 32'd2);

        // R8 control and unmapped reads
        rd(A_CTRL, 32'd0, "R8 control read");
        rd(8'h05, 32'd0, "R8 unmapped low");
        rd(8'h0c, 32'd0, "R8 unmapped high");
        idle(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule